// File: doc/BRIEF.md
# UART transmitter with break generation

This block is the transmit side of an asynchronous serial port. A parallel word is loaded with a valid/ready handshake. It goes out on a single line as a start bit of logic 0, then 8, 9 or 10 data bits with the least significant bit first, then one or two stop bits of logic 1. Each bit lasts exactly one period of an external baud tick, and every character starts on a tick edge.

Besides data frames, the engine sends two special characters:

- A **break** is a stretch of logic 0. Its length is 10 bit times, plus 1 for two stop bits, plus 1 in 9-bit mode or 2 in 10-bit mode, plus 3 when long break is selected. The length therefore runs from 10 to 16 bit times.
- An **idle character** is a full frame length of logic 1. One idle character is queued whenever transmit enable goes from low to high.

Clearing transmit enable never cuts a character short. The character in the shifter always runs to its end, so a low-high pulse of the enable during a frame keeps the line driven and only adds an idle character after that frame.

The control is a four-state machine:

- **ST_IDLE**: line high, waiting.
- **ST_DATA**: shifting a data frame.
- **ST_BREAK**: driving the line low.
- **ST_MARK**: driving the line high for an idle character.

The transitions are:

- **start-mark**, **start-break** and **start-data** leave ST_IDLE on a tick when the enable is high and a job is queued. The queue order is idle character, then break, then data.
- **chain** goes straight from the last bit of one character to the first bit of the next queued one on the same tick.
- **finish** returns to ST_IDLE when nothing is queued.
- **shift** is the per-tick step inside a character.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, with `tx_en` low, `tx_out` is 1 and `ld_ready` is 0.
- R2: A word accepted on a clock edge (`ld_valid` and `ld_ready` both high) starts on the first baud tick after that edge. In 8-bit mode with one stop bit the line then carries 0, then data bits 0 to 7, then one 1. Each bit holds for one tick period, and the line stays 1 after the frame.
- R3: With `cfg_nine` set, 9 data bits are sent. With `cfg_ten` set, 10 data bits are sent whatever `cfg_nine` is.
- R4: With `cfg_two_stop` set, the frame ends with two stop bits of 1.
- R5: A break request sends logic 0 for L bit times, where L = 10 + `cfg_two_stop` + (`cfg_ten` ? 2 : `cfg_nine` ? 1 : 0) + (`cfg_long_brk` ? 3 : 0).
- R6: A rising edge of `tx_en` queues one idle character. It holds `tx_out` at 1 for the current frame length (1 + data bits + stop bits), and `ld_ready` is 0 while it is sent.
- R7: Clearing `tx_en` during a character does not change or shorten that character. Setting `tx_en` again before the character ends queues an idle character that follows it.
- R8: While `tx_en` is low and no character is in progress, `tx_out` stays 1, `ld_ready` is 0 and no character starts. Requests made during that time are kept.
- R9: `ld_ready` is 0 while a character is in progress or a loaded word is still waiting.
- R10: When several jobs are queued at a start point, the idle character goes first, then the break, then the data word.
- R11: A queued job starts on the same tick that ends the previous character, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmit enable; a rising edge queues an idle character |
| brk_req | input | 1 | One-cycle request to queue a break |
| cfg_long_brk | input | 1 | Adds 3 bit times to a break |
| cfg_nine | input | 1 | 9-bit data mode |
| cfg_ten | input | 1 | 10-bit data mode (overrides 9-bit) |
| cfg_two_stop | input | 1 | Two stop bits |
| ld_valid | input | 1 | Load word valid |
| ld_data | input | 10 | Word to send, bit 0 sent first |
| ld_ready | output | 1 | Block can take a word |
| tx_out | output | 1 | Serial line |

## Verification
Every queued request (a word taken on an edge, a break pulse seen on an edge, or an enable rise seen on an edge) leaves the line untouched until the first baud tick strictly after that edge. From that tick, bit k of the character is on the line from tick k until tick k+1, and the line changes on no other clock.

The bench therefore always lets one clock edge pass after driving a request. It then waits for each tick edge and samples `tx_out` and `ld_ready` on the following falling clock edge. Sample k is compared with bit k, and one extra sample after the last bit shows either the return to 1 or the start of a chained character.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_BREAK = 2'd2,
        ST_MARK  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/uart_frame_fmt.sv
`timescale 1ns/1ps
// Builds the shift word and the character lengths from the mode inputs.
module uart_frame_fmt #(
    parameter int DATA_W = 10,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic              nine,
    input  logic              ten,
    input  logic              two_stop,
    input  logic              long_brk,
    output logic [DATA_W+2:0] word,
    output logic [CNT_W-1:0]  frame_len,
    output logic [CNT_W-1:0]  brk_len
);

    int dbits;
    int extra;

    always_comb begin
        if (ten) begin
            dbits = DATA_W;
            extra = 2;
        end else if (nine) begin
            dbits = DATA_W - 1;
            extra = 1;
        end else begin
            dbits = DATA_W - 2;
            extra = 0;
        end
    end

    always_comb begin
        frame_len = CNT_W'(1 + dbits + (two_stop ? 2 : 1));
        brk_len   = CNT_W'(DATA_W + (two_stop ? 1 : 0) + extra + (long_brk ? 3 : 0));
    end

    // Bit 0 is the start bit; unused data slots and everything above are stop level.
    always_comb begin
        word    = '1;
        word[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < dbits) word[i+1] = data[i];
        end
    end

endmodule

// File: rtl/uart_job_queue.sv
`timescale 1ns/1ps
// Holds the pending idle, break and data jobs and the load handshake.
module uart_job_queue #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              shifter_busy,
    input  logic              take_idle,
    input  logic              take_brk,
    input  logic              take_data,
    output logic              ld_ready,
    output logic              idle_pend,
    output logic              brk_pend,
    output logic              data_pend,
    output logic [DATA_W-1:0] data_q
);

    logic en_q;
    logic en_rise;
    logic accept;

    assign en_rise  = tx_en && !en_q;
    assign ld_ready = tx_en && !data_pend && !shifter_busy;
    assign accept   = ld_valid && ld_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            idle_pend <= 1'b0;
            brk_pend  <= 1'b0;
            data_pend <= 1'b0;
            data_q    <= '0;
        end else begin
            en_q <= tx_en;

            if (en_rise)        idle_pend <= 1'b1;
            else if (take_idle) idle_pend <= 1'b0;

            if (brk_req)        brk_pend <= 1'b1;
            else if (take_brk)  brk_pend <= 1'b0;

            if (accept) begin
                data_pend <= 1'b1;
                data_q    <= ld_data;
            end else if (take_data) begin
                data_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_tx_brk.sv
`timescale 1ns/1ps
module uart_tx_brk
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              cfg_long_brk,
    input  logic              cfg_nine,
    input  logic              cfg_ten,
    input  logic              cfg_two_stop,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    output logic              ld_ready,
    output logic              tx_out
);

    localparam int MAX_BITS = DATA_W + 6;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam int SH_W     = DATA_W + 3;

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  bits_left_q, bits_left_d;
    logic [SH_W-1:0]   sh_q, sh_d;

    logic              idle_pend, brk_pend, data_pend;
    logic [DATA_W-1:0] data_q;
    logic              take_idle, take_brk, take_data;
    logic [SH_W-1:0]   frame_word;
    logic [CNT_W-1:0]  frame_len, brk_len;
    logic              end_now, can_start;

    uart_job_queue #(.DATA_W(DATA_W)) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (tx_en),
        .brk_req      (brk_req),
        .ld_valid     (ld_valid),
        .ld_data      (ld_data),
        .shifter_busy (state_q != ST_IDLE),
        .take_idle    (take_idle),
        .take_brk     (take_brk),
        .take_data    (take_data),
        .ld_ready     (ld_ready),
        .idle_pend    (idle_pend),
        .brk_pend     (brk_pend),
        .data_pend    (data_pend),
        .data_q       (data_q)
    );

    uart_frame_fmt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fmt (
        .data      (data_q),
        .nine      (cfg_nine),
        .ten       (cfg_ten),
        .two_stop  (cfg_two_stop),
        .long_brk  (cfg_long_brk),
        .word      (frame_word),
        .frame_len (frame_len),
        .brk_len   (brk_len)
    );

    // A character ends on the tick that closes its last bit.
    assign end_now   = baud_tick && (state_q != ST_IDLE) && (bits_left_q == CNT_W'(1));
    assign can_start = baud_tick && tx_en && ((state_q == ST_IDLE) || end_now);
    assign take_idle = can_start && idle_pend;
    assign take_brk  = can_start && !idle_pend && brk_pend;
    assign take_data = can_start && !idle_pend && !brk_pend && data_pend;

    // Next-state logic.
    always_comb begin
        state_d     = state_q;
        bits_left_d = bits_left_q;
        sh_d        = sh_q;
        if (take_idle) begin
            state_d     = ST_MARK;
            bits_left_d = frame_len;
        end else if (take_brk) begin
            state_d     = ST_BREAK;
            bits_left_d = brk_len;
        end else if (take_data) begin
            state_d     = ST_DATA;
            bits_left_d = frame_len;
            sh_d        = frame_word;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_DATA, ST_BREAK, ST_MARK: begin
                    if (end_now) begin
                        state_d     = ST_IDLE;
                        bits_left_d = '0;
                    end else if (baud_tick) begin
                        bits_left_d = bits_left_q - CNT_W'(1);
                        sh_d        = {1'b1, sh_q[SH_W-1:1]};
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bits_left_q <= '0;
            sh_q        <= '1;
        end else begin
            state_q     <= state_d;
            bits_left_q <= bits_left_d;
            sh_q        <= sh_d;
        end
    end

    // Line output.
    always_comb begin
        unique case (state_q)
            ST_IDLE:  tx_out = 1'b1;
            ST_DATA:  tx_out = sh_q[0];
            ST_BREAK: tx_out = 1'b0;
            ST_MARK:  tx_out = 1'b1;
            default:  tx_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_brk_chk.sv
`timescale 1ns/1ps
module uart_tx_brk_chk
    import uart_tx_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int MAX_BITS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             baud_tick,
    input logic             tx_en,
    input logic             ld_valid,
    input logic             ld_ready,
    input logic             tx_out,
    input tx_state_e        state,
    input logic [CNT_W-1:0] bits_left
);

    // R2: the line only moves on a tick edge
    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_out));

    // R5: a break keeps the line low
    p_break_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK) |-> !tx_out);

    // R5: the bit counter stays within the longest character
    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bits_left) <= MAX_BITS);

    // R8: nothing starts while disabled
    p_disabled_stays_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && state == ST_IDLE) |=> (state == ST_IDLE));

    // R9: ready implies a free, high line
    p_ready_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> tx_out);

    // R9: an accepted word drops ready
    p_take_drops_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> !ld_ready);

endmodule

bind uart_tx_brk uart_tx_brk_chk #(.CNT_W(CNT_W), .MAX_BITS(MAX_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tx_en     (tx_en),
    .ld_valid  (ld_valid),
    .ld_ready  (ld_ready),
    .tx_out    (tx_out),
    .state     (state_q),
    .bits_left (bits_left_q)
);

// File: tb/sim_uart_tx_brk.sv
`timescale 1ns/1ps
module sim_uart_tx_brk;

    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          baud_tick = 1'b0;
    logic          tx_en = 1'b0;
    logic          brk_req = 1'b0;
    logic          cfg_long_brk = 1'b0;
    logic          cfg_nine = 1'b0;
    logic          cfg_ten = 1'b0;
    logic          cfg_two_stop = 1'b0;
    logic          ld_valid = 1'b0;
    logic [DW-1:0] ld_data = '0;
    logic          ld_ready;
    logic          tx_out;

    int total = 0;
    int bad = 0;
    int tcnt = 0;

    uart_tx_brk #(.DATA_W(DW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .tx_en        (tx_en),
        .brk_req      (brk_req),
        .cfg_long_brk (cfg_long_brk),
        .cfg_nine     (cfg_nine),
        .cfg_ten      (cfg_ten),
        .cfg_two_stop (cfg_two_stop),
        .ld_valid     (ld_valid),
        .ld_data      (ld_data),
        .ld_ready     (ld_ready),
        .tx_out       (tx_out)
    );

    always #10 clk = ~clk;

    // One tick every four clocks, changed on the falling edge.
    always @(negedge clk) begin
        if (tcnt == 3) begin
            tcnt      <= 0;
            baud_tick <= 1'b1;
        end else begin
            tcnt      <= tcnt + 1;
            baud_tick <= 1'b0;
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [31:0] act,
                             input logic [31:0] exp, input int n);
        logic [31:0] m;
        m = (n >= 32) ? '1 : ((32'h1 << n) - 32'h1);
        total++;
        if ((act & m) !== (exp & m)) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act & m, exp & m);
        end
    endtask

    // Wait for a tick edge, then sample on the next falling edge.
    task automatic next_tick();
        do @(posedge clk); while (!baud_tick);
        @(negedge clk);
    endtask

    task automatic collect(input int n, output logic [31:0] v);
        v = '0;
        for (int k = 0; k < n; k++) begin
            next_tick();
            v[k] = tx_out;
        end
    endtask

    // Start 0, data lsb first, then ones for stop bits and beyond.
    function automatic logic [31:0] exp_frame(input logic [DW-1:0] d, input int dbits);
        logic [31:0] v;
        v    = '1;
        v[0] = 1'b0;
        for (int i = 0; i < dbits; i++) v[1+i] = d[i];
        return v;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 line after reset", tx_out, 1'b1);
        check_bit("R1 ready while disabled", ld_ready, 1'b0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        @(negedge clk);
        tx_en = 1'b1;
        @(posedge clk);
        collect(1, v);
        check_bit("R6 ready low during idle char", ld_ready, 1'b0);
        collect(10, v);
        check_vec("R6 idle char high", v, 32'hFFFF_FFFF, 10);
        check_bit("R6 ready after idle char", ld_ready, 1'b1);
    endtask

    task automatic t_data(input string req, input logic [DW-1:0] d, input logic nine,
                          input logic ten, input logic two, input int dbits, input int stops);
        logic [31:0] v;
        int n;
        @(negedge clk);
        cfg_nine = nine; cfg_ten = ten; cfg_two_stop = two; cfg_long_brk = 1'b0;
        ld_data  = d;
        ld_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        check_bit("R9 ready low after load", ld_ready, 1'b0);
        n = 1 + dbits + stops;
        collect(n + 1, v);
        check_vec(req, v, exp_frame(d, dbits), n + 1);
    endtask

    task automatic t_break(input logic lng, input logic nine, input logic ten,
                           input logic two, input int len);
        logic [31:0] v;
        @(negedge clk);
        cfg_long_brk = lng; cfg_nine = nine; cfg_ten = ten; cfg_two_stop = two;
        brk_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        brk_req = 1'b0;
        collect(len + 1, v);
        check_vec($sformatf("R5 break length %0d", len), v, 32'h1 << len, len + 1);
    endtask

    // R10/R11: idle char queued with a word; word follows with no gap.
    task automatic t_idle_then_data();
        logic [31:0] v;
        @(negedge clk);
        cfg_nine = 0; cfg_ten = 0; cfg_two_stop = 0; cfg_long_brk = 0;
        tx_en = 1'b0;
        @(negedge clk);
        tx_en    = 1'b1;
        ld_data  = 10'h0C3;
        ld_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        collect(21, v);
        check_vec("R10 R11 idle then data back to back", v,
                  (exp_frame(10'h0C3, 8) << 10) | 32'h3FF, 21);
    endtask

    // R7: enable pulsed low during a frame.
    task automatic t_mid_frame();
        logic [31:0] e, v;
        e = exp_frame(10'h05A, 8);
        @(negedge clk);
        ld_data  = 10'h05A;
        ld_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        collect(3, v);
        check_vec("R7 first bits", v, e, 3);
        check_bit("R9 ready low mid frame", ld_ready, 1'b0);
        tx_en = 1'b0;
        collect(2, v);
        check_vec("R7 bits with enable low", v, e >> 3, 2);
        tx_en = 1'b1;
        collect(5, v);
        check_vec("R7 frame finishes", v, e >> 5, 5);
        collect(1, v);
        check_bit("R7 idle char follows frame", ld_ready, 1'b0);
        collect(10, v);
        check_vec("R7 line held high", v, 32'hFFFF_FFFF, 10);
        check_bit("R6 ready after queued idle", ld_ready, 1'b1);
    endtask

    // R8/R10: requests while disabled are held; idle goes before break.
    task automatic t_disabled();
        logic [31:0] v;
        @(negedge clk);
        cfg_nine = 0; cfg_ten = 0; cfg_two_stop = 0; cfg_long_brk = 0;
        tx_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_bit("R8 ready low when disabled", ld_ready, 1'b0);
        brk_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        brk_req = 1'b0;
        collect(3, v);
        check_vec("R8 line high while disabled", v, 32'h7, 3);
        check_bit("R8 ready still low", ld_ready, 1'b0);
        tx_en = 1'b1;
        @(posedge clk);
        collect(21, v);
        check_vec("R10 idle before held break", v, 32'h3FF | (32'h1 << 20), 21);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_enable();
        t_data("R2 8-bit frame", 10'h0A5, 0, 0, 0, 8, 1);
        t_data("R3 R4 9-bit two stop", 10'h1C3, 1, 0, 1, 9, 2);
        t_data("R3 10-bit overrides 9-bit", 10'h2F1, 1, 1, 0, 10, 1);
        t_data("R4 8-bit two stop", 10'h03C, 0, 0, 1, 8, 2);
        t_break(0, 0, 0, 0, 10);
        t_break(0, 0, 0, 1, 11);
        t_break(1, 1, 1, 1, 16);
        t_break(1, 1, 0, 0, 14);
        t_idle_then_data();
        t_mid_frame();
        t_disabled();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule